// File: doc/BRIEF.md
# NoC Packet Reassembly Input Port

This block sits on the receive side of a network interface, between a router link and a local bus master. Flits arrive one per cycle, each tagged with a virtual network and a virtual channel. Every (virtual network, virtual channel) pair owns a private buffer large enough for a whole packet, so flits of different packets may interleave on the link. Once the final flit of a packet is stored, the packet competes for a place in a small multi-slot message queue. When it wins a place, its contents are copied there, the buffer is freed, and one credit goes back upstream.

The queue hands its oldest message to the bus side as a stream of narrow beats, using a valid/ready handshake. A message of L flits leaves as L times (flit width / beat width) beats. Within each flit the low-order beat goes first, and the final beat is flagged. The upstream router must follow credit-based flow control: it starts a new packet on a pair only after the credit for the previous packet on that pair has returned.

Top module: `noc_reassembly_port`

## Requirements
- R1: After reset, `beatValid` and `creditValid` are low, and they stay low until a packet has been received.
- R2: Each pair has its own buffer, with index = vnet*NUM_VC + vc. When flits of packets on different pairs interleave, each message carries only its own flits, in arrival order.
- R3: The flit kind encoding is 0 head, 1 body, 2 tail, 3 single-flit packet. A packet becomes eligible for the queue only after its tail or single flit is stored. Uncontended messages leave in the order in which they completed.
- R4: A message of L flits leaves as L*FLIT_W/BEAT_W beats. Flits go out in arrival order, and within each flit the beats go out from bit 0 upward. `beatLast` is high only on the final beat.
- R5: A beat transfers only on a cycle where `beatValid` and `beatReady` are both high. While the beat is held back, `beatData` and `beatLast` do not change.
- R6: The queue holds at most MSG_SLOTS messages. While it is full, completed packets wait in their buffers and nothing is lost.
- R7: Completed packets that compete for the queue are served round-robin by buffer index. The search starts at the index after the last one granted.
- R8: Each packet returns exactly one credit, a one-cycle `creditValid` pulse carrying its vnet and vc. The pulse comes when the packet's buffer is released.
- R9: When the queue is empty and idle, `beatValid` rises on the second clock edge after the edge that stores the tail flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flitValid | input | 1 | A flit is present this cycle |
| flitKind | input | 2 | 0 head, 1 body, 2 tail, 3 single |
| flitVnet | input | VNET_W | Virtual network of the flit |
| flitVc | input | VC_W | Virtual channel within the network |
| flitData | input | FLIT_W | Flit payload |
| creditValid | output | 1 | One buffer was released this cycle |
| creditVnet | output | VNET_W | Virtual network of the released buffer |
| creditVc | output | VC_W | Virtual channel of the released buffer |
| beatValid | output | 1 | A message beat is offered |
| beatData | output | BEAT_W | Beat payload |
| beatLast | output | 1 | Final beat of the message |
| beatReady | input | 1 | Bus master accepts the beat |

## Verification
The bench interleaves the flits of two packets on different pairs and expects the packet that completes first to leave first. A design that shares storage between pairs, or orders messages by head arrival, would mix payloads or swap the two messages. The bench fills the queue while the bus stalls, then completes two more packets in the order buffer 3, buffer 1. It expects exactly six credits while the queue is blocked, and after the release it expects buffer 1 to drain before buffer 3. A design that overwrote a slot, dropped a waiting packet, or used fixed priority or first-come ordering would miss a credit, lose beats, or deliver the messages in the wrong order. The bench also covers single-flit and maximum-length packets, random backpressure with a beat that must hold steady, and the exact cycle of the first beat. These catch wrong beat ordering, a misplaced last flag, and an extra pipeline register.

// File: rtl/noc_reasm_pkg.sv
package noc_reasm_pkg;

  // flit kind codes carried on the link
  typedef enum logic [1:0] {
    KIND_HEAD   = 2'd0,
    KIND_BODY   = 2'd1,
    KIND_TAIL   = 2'd2,
    KIND_SINGLE = 2'd3
  } flitKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic flitWr;   // store incoming flit into a packet buffer
    logic copyEn;   // move a whole packet buffer into a queue slot
  } dpStrobe_t;

endpackage

// File: rtl/reasm_rr_arb.sv
module reasm_rr_arb #(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     req,
  input  logic             advance,
  output logic             gntValid,
  output logic [IDX_W-1:0] gntIdx
);

  logic [IDX_W-1:0] ptr;

  always_comb begin
    int cand;
    gntValid = 1'b0;
    gntIdx   = '0;
    // walk offsets downward so the smallest offset from ptr wins
    for (int k = N - 1; k >= 0; k--) begin
      cand = int'(ptr) + k;
      if (cand >= N) cand = cand - N;
      if (req[cand]) begin
        gntValid = 1'b1;
        gntIdx   = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= (gntIdx == IDX_W'(N - 1)) ? '0 : gntIdx + 1'b1;
    end
  end

  assert_grant_is_request_R7: assert property (@(posedge clk) disable iff (!rstN)
    advance |-> gntValid && req[gntIdx]);

endmodule

// File: rtl/reasm_ctrl.sv
module reasm_ctrl
  import noc_reasm_pkg::*;
#(
  parameter int NUM_VNET       = 3,
  parameter int NUM_VC         = 2,
  parameter int MAX_FLITS      = 4,
  parameter int MSG_SLOTS      = 6,
  parameter int BEATS_PER_FLIT = 2,
  localparam int NUM_BUF   = NUM_VNET * NUM_VC,
  localparam int BUF_W     = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int VNET_W    = (NUM_VNET > 1) ? $clog2(NUM_VNET) : 1,
  localparam int VC_W      = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int POS_W     = (MAX_FLITS > 1) ? $clog2(MAX_FLITS) : 1,
  localparam int SLOT_W    = (MSG_SLOTS > 1) ? $clog2(MSG_SLOTS) : 1,
  localparam int NUM_BEATS = MAX_FLITS * BEATS_PER_FLIT,
  localparam int BSEL_W    = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flitValid,
  input  logic [1:0]        flitKind,
  input  logic [VNET_W-1:0] flitVnet,
  input  logic [VC_W-1:0]   flitVc,
  input  logic              beatReady,
  output dpStrobe_t         strobe,
  output logic [BUF_W-1:0]  flitBuf,
  output logic [POS_W-1:0]  flitPos,
  output logic [BUF_W-1:0]  copySrc,
  output logic [SLOT_W-1:0] copySlot,
  output logic [SLOT_W-1:0] headSlot,
  output logic [BSEL_W-1:0] beatSel,
  output logic              beatValid,
  output logic              beatLast,
  output logic              creditValid,
  output logic [VNET_W-1:0] creditVnet,
  output logic [VC_W-1:0]   creditVc
);

  localparam int CNT_W   = $clog2(MAX_FLITS + 1);
  localparam int QCNT_W  = $clog2(MSG_SLOTS + 1);
  localparam int BTOT_W  = $clog2(NUM_BEATS + 1);

  // per-buffer state
  logic [CNT_W-1:0] fillCnt [NUM_BUF];
  logic [NUM_BUF-1:0] complete;
  logic [NUM_BUF-1:0] claimed;

  // handoff stage
  logic             copyValid;
  logic [BUF_W-1:0] copyIdx;
  logic [BUF_W-1:0] creditBuf;

  // message queue bookkeeping
  logic [CNT_W-1:0]  slotLen [MSG_SLOTS];
  logic [SLOT_W-1:0] tailPtr;
  logic [SLOT_W-1:0] headPtr;
  logic [QCNT_W-1:0] qCount;

  logic [BUF_W-1:0] wrIdx;
  logic             isStart;
  logic             isEnd;
  logic             gntValid;
  logic [BUF_W-1:0] gntIdx;
  logic             roomFree;
  logic             take;
  logic             pop;
  logic [BTOT_W-1:0] beatsTotal;

  function automatic logic [SLOT_W-1:0] nextSlot(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(MSG_SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wrIdx   = BUF_W'(flitVnet) * BUF_W'(NUM_VC) + BUF_W'(flitVc);
    isStart = (flitKind == KIND_HEAD) || (flitKind == KIND_SINGLE);
    isEnd   = (flitKind == KIND_TAIL) || (flitKind == KIND_SINGLE);
  end

  // queue room counts the packet already in the handoff stage
  assign roomFree = (int'(qCount) + int'(copyValid)) < MSG_SLOTS;
  assign take     = gntValid && roomFree;

  reasm_rr_arb #(.N(NUM_BUF), .IDX_W(BUF_W)) u_arb (
    .clk      (clk),
    .rstN     (rstN),
    .req      (complete & ~claimed),
    .advance  (take),
    .gntValid (gntValid),
    .gntIdx   (gntIdx)
  );

  // drain side
  assign beatValid  = (qCount != '0);
  assign beatsTotal = BTOT_W'(slotLen[headPtr]) * BTOT_W'(BEATS_PER_FLIT);
  assign beatLast   = beatValid && ((BTOT_W'(beatSel) + BTOT_W'(1)) == beatsTotal);
  assign pop        = beatValid && beatReady && beatLast;

  // datapath controls
  always_comb begin
    strobe.flitWr = flitValid;
    strobe.copyEn = copyValid;
    flitBuf  = wrIdx;
    flitPos  = isStart ? '0 : POS_W'(fillCnt[wrIdx]);
    copySrc  = copyIdx;
    copySlot = tailPtr;
    headSlot = headPtr;
  end

  assign creditVnet = VNET_W'(int'(creditBuf) / NUM_VC);
  assign creditVc   = VC_W'(int'(creditBuf) % NUM_VC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BUF; i++) fillCnt[i] <= '0;
      for (int s = 0; s < MSG_SLOTS; s++) slotLen[s] <= '0;
      complete    <= '0;
      claimed     <= '0;
      copyValid   <= 1'b0;
      copyIdx     <= '0;
      creditValid <= 1'b0;
      creditBuf   <= '0;
      tailPtr     <= '0;
      headPtr     <= '0;
      qCount      <= '0;
      beatSel     <= '0;
    end else begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (flitValid && wrIdx == BUF_W'(i)) begin
          fillCnt[i] <= isStart ? CNT_W'(1) : fillCnt[i] + 1'b1;
          if (isEnd) complete[i] <= 1'b1;
        end
        if (take && gntIdx == BUF_W'(i)) claimed[i] <= 1'b1;
        if (copyValid && copyIdx == BUF_W'(i)) begin
          fillCnt[i]  <= '0;
          complete[i] <= 1'b0;
          claimed[i]  <= 1'b0;
        end
      end

      copyValid   <= take;
      copyIdx     <= gntIdx;
      creditValid <= copyValid;
      creditBuf   <= copyIdx;

      if (copyValid) begin
        slotLen[tailPtr] <= fillCnt[copyIdx];
        tailPtr          <= nextSlot(tailPtr);
      end

      if (pop) begin
        headPtr <= nextSlot(headPtr);
        beatSel <= '0;
      end else if (beatValid && beatReady) begin
        beatSel <= beatSel + 1'b1;
      end

      case ({copyValid, pop})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(qCount) <= MSG_SLOTS);

  assert_body_fits_R2: assert property (@(posedge clk) disable iff (!rstN)
    flitValid && !isStart |-> fillCnt[wrIdx] != '0 && int'(fillCnt[wrIdx]) < MAX_FLITS);

  assert_no_write_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    flitValid |-> !complete[wrIdx]);

  assert_credit_frees_R8: assert property (@(posedge clk) disable iff (!rstN)
    creditValid |-> fillCnt[creditBuf] == '0 && !complete[creditBuf]);

endmodule

// File: rtl/reasm_dp.sv
module reasm_dp
  import noc_reasm_pkg::*;
#(
  parameter int NUM_BUF   = 6,
  parameter int MAX_FLITS = 4,
  parameter int MSG_SLOTS = 6,
  parameter int FLIT_W    = 64,
  parameter int BEAT_W    = 32,
  localparam int BUF_W     = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int POS_W     = (MAX_FLITS > 1) ? $clog2(MAX_FLITS) : 1,
  localparam int SLOT_W    = (MSG_SLOTS > 1) ? $clog2(MSG_SLOTS) : 1,
  localparam int MSG_W     = MAX_FLITS * FLIT_W,
  localparam int NUM_BEATS = MSG_W / BEAT_W,
  localparam int BSEL_W    = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1
) (
  input  logic              clk,
  input  dpStrobe_t         strobe,
  input  logic [BUF_W-1:0]  flitBuf,
  input  logic [POS_W-1:0]  flitPos,
  input  logic [FLIT_W-1:0] flitData,
  input  logic [BUF_W-1:0]  copySrc,
  input  logic [SLOT_W-1:0] copySlot,
  input  logic [SLOT_W-1:0] headSlot,
  input  logic [BSEL_W-1:0] beatSel,
  output logic [BEAT_W-1:0] beatData
);

  logic [FLIT_W-1:0] bufMem  [NUM_BUF][MAX_FLITS];
  logic [MSG_W-1:0]  slotMem [MSG_SLOTS];
  logic [MSG_W-1:0]  headMsg;
  logic [BEAT_W-1:0] headBeats [NUM_BEATS];

  always_ff @(posedge clk) begin
    if (strobe.flitWr) bufMem[flitBuf][flitPos] <= flitData;
    if (strobe.copyEn) begin
      for (int f = 0; f < MAX_FLITS; f++) begin
        slotMem[copySlot][f*FLIT_W +: FLIT_W] <= bufMem[copySrc][f];
      end
    end
  end

  assign headMsg = slotMem[headSlot];

  for (genvar b = 0; b < NUM_BEATS; b++) begin : g_beat
    assign headBeats[b] = headMsg[b*BEAT_W +: BEAT_W];
  end

  assign beatData = headBeats[beatSel];

endmodule

// File: rtl/noc_reassembly_port.sv
module noc_reassembly_port
  import noc_reasm_pkg::*;
#(
  parameter int NUM_VNET  = 3,
  parameter int NUM_VC    = 2,
  parameter int FLIT_W    = 64,
  parameter int MAX_FLITS = 4,
  parameter int MSG_SLOTS = 6,
  parameter int BEAT_W    = 32,
  localparam int VNET_W    = (NUM_VNET > 1) ? $clog2(NUM_VNET) : 1,
  localparam int VC_W      = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flitValid,
  input  logic [1:0]        flitKind,
  input  logic [VNET_W-1:0] flitVnet,
  input  logic [VC_W-1:0]   flitVc,
  input  logic [FLIT_W-1:0] flitData,
  output logic              creditValid,
  output logic [VNET_W-1:0] creditVnet,
  output logic [VC_W-1:0]   creditVc,
  output logic              beatValid,
  output logic [BEAT_W-1:0] beatData,
  output logic              beatLast,
  input  logic              beatReady
);

  localparam int NUM_BUF        = NUM_VNET * NUM_VC;
  localparam int BEATS_PER_FLIT = FLIT_W / BEAT_W;
  localparam int BUF_W          = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam int POS_W          = (MAX_FLITS > 1) ? $clog2(MAX_FLITS) : 1;
  localparam int SLOT_W         = (MSG_SLOTS > 1) ? $clog2(MSG_SLOTS) : 1;
  localparam int NUM_BEATS      = MAX_FLITS * BEATS_PER_FLIT;
  localparam int BSEL_W         = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1;

  dpStrobe_t         strobe;
  logic [BUF_W-1:0]  flitBuf;
  logic [POS_W-1:0]  flitPos;
  logic [BUF_W-1:0]  copySrc;
  logic [SLOT_W-1:0] copySlot;
  logic [SLOT_W-1:0] headSlot;
  logic [BSEL_W-1:0] beatSel;

  reasm_ctrl #(
    .NUM_VNET(NUM_VNET), .NUM_VC(NUM_VC), .MAX_FLITS(MAX_FLITS),
    .MSG_SLOTS(MSG_SLOTS), .BEATS_PER_FLIT(BEATS_PER_FLIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .flitValid(flitValid), .flitKind(flitKind), .flitVnet(flitVnet), .flitVc(flitVc),
    .beatReady(beatReady),
    .strobe(strobe), .flitBuf(flitBuf), .flitPos(flitPos),
    .copySrc(copySrc), .copySlot(copySlot), .headSlot(headSlot), .beatSel(beatSel),
    .beatValid(beatValid), .beatLast(beatLast),
    .creditValid(creditValid), .creditVnet(creditVnet), .creditVc(creditVc)
  );

  reasm_dp #(
    .NUM_BUF(NUM_BUF), .MAX_FLITS(MAX_FLITS), .MSG_SLOTS(MSG_SLOTS),
    .FLIT_W(FLIT_W), .BEAT_W(BEAT_W)
  ) u_dp (
    .clk(clk), .strobe(strobe), .flitBuf(flitBuf), .flitPos(flitPos), .flitData(flitData),
    .copySrc(copySrc), .copySlot(copySlot), .headSlot(headSlot), .beatSel(beatSel),
    .beatData(beatData)
  );

  assert_hold_beat_R5: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !beatReady |=> beatValid && $stable(beatData) && $stable(beatLast));

  assert_pair_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    flitValid |-> int'(flitVnet) < NUM_VNET && int'(flitVc) < NUM_VC);

  assert_quiet_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !beatValid && !creditValid);

endmodule

// File: tb/tb_noc_reassembly_port.sv
module tb_noc_reassembly_port;
  localparam int NV = 3, NC = 2, FW = 64, MF = 4, MS = 6, BW = 32;
  localparam int NB = NV * NC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          flitValid = 1'b0;
  logic [1:0]    flitKind  = 2'd0;
  logic [1:0]    flitVnet  = '0;
  logic [0:0]    flitVc    = '0;
  logic [FW-1:0] flitData  = '0;
  logic          beatReady = 1'b0;
  logic          creditValid;
  logic [1:0]    creditVnet;
  logic [0:0]    creditVc;
  logic          beatValid;
  logic [BW-1:0] beatData;
  logic          beatLast;

  noc_reassembly_port #(.NUM_VNET(NV), .NUM_VC(NC), .FLIT_W(FW), .MAX_FLITS(MF),
                        .MSG_SLOTS(MS), .BEAT_W(BW)) dut (
    .clk(clk), .rstN(rstN), .flitValid(flitValid), .flitKind(flitKind),
    .flitVnet(flitVnet), .flitVc(flitVc), .flitData(flitData),
    .creditValid(creditValid), .creditVnet(creditVnet), .creditVc(creditVc),
    .beatValid(beatValid), .beatData(beatData), .beatLast(beatLast), .beatReady(beatReady)
  );

  int checks = 0, fails = 0;
  string phase = "R3";
  logic [BW:0] expQ[$];   // {last, data}
  int credCnt[NB];
  int sentCnt[NB];
  int readyMode = 0;
  logic [7:0] lfsr = 8'h5a;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ready driver, away from the active edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (readyMode)
      0:       beatReady = 1'b0;
      1:       beatReady = 1'b1;
      default: beatReady = lfsr[0];
    endcase
  end

  // scoreboard monitor and credit counter
  always @(negedge clk) begin : mon
    logic [BW:0] e;
    if (rstN) begin
      if (beatValid && beatReady) begin
        if (expQ.size() == 0) begin
          check(0, {phase, " R4"}, "unexpected beat", {31'd0, beatLast, beatData}, 64'd0);
        end else begin
          e = expQ.pop_front();
          check({beatLast, beatData} == e, {phase, " R4"}, "beat {last,data}",
                {31'd0, beatLast, beatData}, {31'd0, e});
        end
      end
      if (creditValid) credCnt[int'(creditVnet) * NC + int'(creditVc)]++;
    end
  end

  function automatic logic [31:0] mkLo(int pkt, int f);
    return {pkt[15:0], f[7:0], 8'hA0};
  endfunction
  function automatic logic [31:0] mkHi(int pkt, int f);
    return {pkt[15:0], f[7:0], 8'hB1};
  endfunction

  task automatic pushMsg(int pkt, int len);
    for (int f = 0; f < len; f++) begin
      expQ.push_back({1'b0, mkLo(pkt, f)});
      expQ.push_back({(f == len - 1), mkHi(pkt, f)});
    end
  endtask

  task automatic sendFlit(logic [1:0] kind, int vn, int vc, int pkt, int f);
    flitValid = 1'b1;
    flitKind  = kind;
    flitVnet  = 2'(vn);
    flitVc    = 1'(vc);
    flitData  = {mkHi(pkt, f), mkLo(pkt, f)};
    @(posedge clk);
    #1;
    flitValid = 1'b0;
  endtask

  // kinds: 0 head, 1 body, 2 tail, 3 single (R3)
  task automatic sendPacket(int vn, int vc, int pkt, int len, bit push);
    logic [1:0] k;
    if (push) pushMsg(pkt, len);
    sentCnt[vn * NC + vc]++;
    for (int f = 0; f < len; f++) begin
      k = (len == 1) ? 2'd3 : (f == 0) ? 2'd0 : (f == len - 1) ? 2'd2 : 2'd1;
      sendFlit(k, vn, vc, pkt, f);
    end
  endtask

  task automatic waitDrain();
    int n = 0;
    while (expQ.size() != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (6) @(negedge clk);
  endtask

  function automatic int sumArr(input int a[NB]);
    int s = 0;
    for (int i = 0; i < NB; i++) s += a[i];
    return s;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    logic [BW-1:0] held;
    for (int i = 0; i < NB; i++) begin credCnt[i] = 0; sentCnt[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check(beatValid == 1'b0, "R1", "beatValid after reset", {63'd0, beatValid}, 64'd0);
    check(creditValid == 1'b0, "R1", "creditValid after reset", {63'd0, creditValid}, 64'd0);

    // R9: first beat latency
    phase = "R9";
    readyMode = 1;
    sendPacket(0, 0, 1, 2, 1);
    @(negedge clk);
    check(beatValid == 1'b0, "R9", "valid one edge after tail", {63'd0, beatValid}, 64'd0);
    @(negedge clk);
    check(beatValid == 1'b0, "R9", "valid two edges after tail", {63'd0, beatValid}, 64'd0);
    @(negedge clk);
    check(beatValid == 1'b1, "R9", "valid three edges after tail", {63'd0, beatValid}, 64'd1);
    waitDrain();

    // R3/R4: single, maximum and mid-length packets under random backpressure
    phase = "R3";
    readyMode = 2;
    sendPacket(1, 1, 2, 1, 1);
    sendPacket(2, 0, 3, MF, 1);
    sendPacket(0, 1, 4, 3, 1);
    sendPacket(2, 1, 5, 1, 1);
    waitDrain();

    // R2: interleaved flits on two pairs; B finishes first
    phase = "R2";
    readyMode = 1;
    pushMsg(21, 2);
    pushMsg(20, 3);
    sentCnt[1 * NC + 0]++;
    sentCnt[2 * NC + 1]++;
    sendFlit(2'd0, 1, 0, 20, 0);
    sendFlit(2'd0, 2, 1, 21, 0);
    sendFlit(2'd1, 1, 0, 20, 1);
    sendFlit(2'd2, 2, 1, 21, 1);
    sendFlit(2'd2, 1, 0, 20, 2);
    waitDrain();

    // R6/R7/R5: fill the queue with the bus stalled
    phase = "R7";
    readyMode = 0;
    repeat (2) @(negedge clk);
    base = sumArr(credCnt);
    for (int i = 0; i < NB; i++) sendPacket(i / NC, i % NC, 40 + i, 2, 1);
    sendPacket(1, 1, 50, 2, 0);   // buffer 3 completes first
    sendPacket(0, 1, 51, 2, 0);   // buffer 1 completes second
    repeat (8) @(negedge clk);
    check(sumArr(credCnt) == base + MS, "R6", "credits while queue full",
          64'(sumArr(credCnt) - base), 64'(MS));
    held = beatData;
    check(beatValid == 1'b1, "R5", "valid while stalled", {63'd0, beatValid}, 64'd1);
    repeat (3) @(negedge clk);
    check(beatValid == 1'b1 && beatData == held && beatLast == 1'b0, "R5",
          "held beat stable", {31'd0, beatLast, beatData}, {32'd0, held});
    // round-robin from index 0 after last grant of index 5: buffer 1 before 3
    pushMsg(51, 2);
    pushMsg(50, 2);
    readyMode = 1;
    waitDrain();

    // end checks
    phase = "R8";
    check(expQ.size() == 0, "R6", "messages left undelivered", 64'(expQ.size()), 64'd0);
    for (int i = 0; i < NB; i++)
      check(credCnt[i] == sentCnt[i], "R8", $sformatf("credits for buffer %0d", i),
            64'(credCnt[i]), 64'(sentCnt[i]));
    finished = 1;
    summary();
    $finish;
  end

endmodule